// File: doc/BRIEF.md
# Shared Issue-Queue Capacity Allocator

This block tracks how many entries of a shared issue queue each hardware thread holds and decides whether a new entry may be allocated. It keeps one global free counter, one occupancy counter per thread and one ceiling per thread. From these it reports a free count and a full flag for every thread and for the queue as a whole. The queue storage and the selection of entries to issue are outside the block. The block only does the capacity bookkeeping that the dispatch logic consults.

Each cycle it takes at most one allocation request. It also takes one release on each of two release ports. The issue port is for entries that leave at issue or at squash. The memory port is for memory-reference entries, which leave only when the memory operation completes. A configuration update loads a new active-thread mask and a sharing mode. The control state machine has two states. In RUN the ceilings hold. In RECALC the ceilings are rewritten from the latched mode and mask. Accepting a configuration update moves RUN to RECALC. RECALC returns to RUN unless a further update arrives, in which case it stays in RECALC. Sharing modes are encoded on `cfg_mode`: 2'b00 shared (dynamic), 2'b01 even split (partitioned), 2'b10 percentage threshold. 2'b11 behaves as shared.

Top module: `iq_share_alloc`

## Requirements
- R1: After reset the mode is shared, the active mask is all ones, every thread's free count and the queue free count equal NUM_ENTRIES, and no full flag is set.
- R2: In shared mode (`cfg_mode` 2'b00, and also 2'b11) every thread's ceiling is NUM_ENTRIES.
- R3: In split mode (2'b01) each thread whose bit in the active mask is 1 gets a ceiling of NUM_ENTRIES divided by the number of active threads, truncated. Threads with a 0 bit keep their previous ceiling. An all-zero mask leaves every ceiling unchanged.
- R4: In threshold mode (2'b10) every ceiling is THRESH_PCT*NUM_ENTRIES/100, truncated. The one exception is when exactly one thread is active: that thread's ceiling is NUM_ENTRIES.
- R5: A configuration accepted at clock edge k raises `cfg_busy` after edge k. The new ceilings appear after edge k+1. `cfg_busy` falls after edge k+1 unless another update arrived in that cycle.
- R6: A thread's free count is its ceiling minus its occupancy, or 0 when the occupancy is at or above the ceiling. `thr_full` of that thread is 1 when this count is 0.
- R7: `q_free` equals NUM_ENTRIES minus the sum of all occupancies. `q_full` is 1 when `q_free` is 0.
- R8: A request is granted in the same cycle when its thread is not full and the queue is not full. After the edge the thread's occupancy is one higher and `q_free` is one lower.
- R9: A refused request raises `alloc_reject` in the same cycle and changes no count.
- R10: Each release port takes one entry from the named thread. A release to a thread with occupancy 0 is ignored. Two releases to a thread holding one entry take only that one.
- R11: A grant and a release for the same thread in one cycle leave its occupancy unchanged. The grant is judged on the counts held before that cycle's releases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_vld | input | 1 | Allocation request |
| alloc_tid | input | TIDW | Thread of the request |
| rel_iss_vld | input | 1 | Release at issue or squash |
| rel_iss_tid | input | TIDW | Thread of the issue release |
| rel_mem_vld | input | 1 | Release at memory completion |
| rel_mem_tid | input | TIDW | Thread of the memory release |
| cfg_vld | input | 1 | Load a new mask and mode |
| cfg_mask | input | NUM_THREADS | Active-thread mask, bit t is thread t |
| cfg_mode | input | 2 | Sharing mode encoding as in R2 to R4 |
| alloc_grant | output | 1 | Request accepted this cycle |
| alloc_reject | output | 1 | Request refused this cycle |
| thr_full | output | NUM_THREADS | Per-thread full flags |
| thr_free | output | NUM_THREADS*CW | Per-thread free counts, thread t at bits [t*CW +: CW] |
| q_full | output | 1 | Queue has no free entry |
| q_free | output | CW | Queue free entry count |
| cfg_busy | output | 1 | Controller is in RECALC |

## Verification
The bench builds the block with NUM_ENTRIES=10, NUM_THREADS=4 and THRESH_PCT=35. With these values the threshold ceiling truncates from 3.5 to 3, and a three-thread split truncates 10/3 to 3. A handful of grants fills the whole queue, so the global-full refusal and the case where a ceiling shrinks below a thread's occupancy can both be reached in a short run. Four threads allow masks with zero, one, two, three and four active bits, which covers every split divisor, the single-thread threshold raise, and back-to-back configuration updates that keep the controller in RECALC.

// File: rtl/iqsa_pkg.sv
package iqsa_pkg;

    typedef enum logic [1:0] {
        SHARE_DYN  = 2'b00,
        SHARE_PART = 2'b01,
        SHARE_THR  = 2'b10,
        SHARE_RSV  = 2'b11
    } share_mode_e;

    typedef enum logic {
        ST_RUN    = 1'b0,
        ST_RECALC = 1'b1
    } ctl_state_e;

endpackage

// File: rtl/iqsa_ctrl_fsm.sv
module iqsa_ctrl_fsm
    import iqsa_pkg::*;
#(
    parameter int NUM_THREADS = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cfg_vld,
    input  logic [NUM_THREADS-1:0] cfg_mask,
    input  share_mode_e            cfg_mode,
    output logic [NUM_THREADS-1:0] mask_q,
    output share_mode_e            mode_q,
    output logic                   recalc
);

    ctl_state_e state_q, state_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:    state_d = cfg_vld ? ST_RECALC : ST_RUN;
            ST_RECALC: state_d = cfg_vld ? ST_RECALC : ST_RUN;
            default:   state_d = ST_RUN;
        endcase
    end

    // latched configuration
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '1;
            mode_q <= SHARE_DYN;
        end else if (cfg_vld) begin
            mask_q <= cfg_mask;
            mode_q <= cfg_mode;
        end
    end

    // outputs
    always_comb begin
        recalc = 1'b0;
        unique case (state_q)
            ST_RUN:    recalc = 1'b0;
            ST_RECALC: recalc = 1'b1;
            default:   recalc = 1'b0;
        endcase
    end

    // R5: an update always leads into RECALC
    a_r5_cfg_enters_recalc: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_vld |=> recalc);
    // R5: RECALC lasts one cycle without a further update
    a_r5_recalc_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (recalc && !cfg_vld) |=> !recalc);

endmodule

// File: rtl/iqsa_ceiling_calc.sv
module iqsa_ceiling_calc
    import iqsa_pkg::*;
#(
    parameter int NUM_THREADS = 4,
    parameter int NUM_ENTRIES = 32,
    parameter int THRESH_PCT  = 50,
    parameter int CW          = $clog2(NUM_ENTRIES + 1)
) (
    input  share_mode_e                      mode,
    input  logic [NUM_THREADS-1:0]           mask,
    input  logic [NUM_THREADS-1:0][CW-1:0]   ceil_cur,
    output logic [NUM_THREADS-1:0][CW-1:0]   ceil_nxt
);

    localparam int NW = $clog2(NUM_THREADS + 1);
    localparam logic [CW-1:0] FULL_C = CW'(NUM_ENTRIES);
    localparam logic [CW-1:0] THR_C  = CW'((THRESH_PCT * NUM_ENTRIES) / 100);

    logic [CW-1:0] part_tab [0:NUM_THREADS];
    logic [NW-1:0] act_cnt;

    assign part_tab[0] = '0;
    for (genvar k = 1; k <= NUM_THREADS; k++) begin : g_part
        assign part_tab[k] = CW'(NUM_ENTRIES / k);
    end

    always_comb begin
        act_cnt = '0;
        for (int t = 0; t < NUM_THREADS; t++) begin
            act_cnt = act_cnt + NW'(mask[t]);
        end
    end

    always_comb begin
        for (int t = 0; t < NUM_THREADS; t++) begin
            unique case (mode)
                SHARE_PART: ceil_nxt[t] = (mask[t] && act_cnt != '0)
                                          ? part_tab[act_cnt] : ceil_cur[t];
                SHARE_THR:  ceil_nxt[t] = (mask[t] && act_cnt == NW'(1))
                                          ? FULL_C : THR_C;
                default:    ceil_nxt[t] = FULL_C;
            endcase
        end
    end

endmodule

// File: rtl/iqsa_thread_ctr.sv
module iqsa_thread_ctr #(
    parameter int NUM_ENTRIES = 32,
    parameter int CW          = $clog2(NUM_ENTRIES + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          inc,
    input  logic          dec_a,
    input  logic          dec_b,
    input  logic [CW-1:0] ceil,
    output logic [CW-1:0] occ,
    output logic [CW-1:0] free,
    output logic          full,
    output logic [1:0]    rel_cnt
);

    logic [CW-1:0] occ_q;

    always_comb begin
        unique case ({dec_a, dec_b})
            2'b11:        rel_cnt = (occ_q >= CW'(2)) ? 2'd2 : occ_q[1:0];
            2'b10, 2'b01: rel_cnt = (occ_q != '0) ? 2'd1 : 2'd0;
            default:      rel_cnt = 2'd0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) occ_q <= '0;
        else        occ_q <= occ_q + CW'(inc) - CW'(rel_cnt);
    end

    assign occ  = occ_q;
    assign free = (ceil > occ_q) ? (ceil - occ_q) : '0;
    assign full = (free == '0);

    // R11: grant plus a single effective release keeps occupancy
    a_r11_alloc_release_balance: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && (dec_a ^ dec_b) && occ_q != '0) |=> (occ_q == $past(occ_q)));
    // R10: releases never drive an empty thread below zero
    a_r10_empty_release: assert property (@(posedge clk) disable iff (!rst_n)
        (occ_q == '0 && !inc) |=> (occ_q == '0));
    // R6: occupancy never exceeds the queue size
    a_r6_occ_bound: assert property (@(posedge clk) disable iff (!rst_n)
        occ_q <= CW'(NUM_ENTRIES));

endmodule

// File: rtl/iq_share_alloc.sv
module iq_share_alloc
    import iqsa_pkg::*;
#(
    parameter int NUM_THREADS = 4,
    parameter int NUM_ENTRIES = 32,
    parameter int THRESH_PCT  = 50,
    localparam int TIDW = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1,
    localparam int CW   = $clog2(NUM_ENTRIES + 1)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      alloc_vld,
    input  logic [TIDW-1:0]           alloc_tid,
    input  logic                      rel_iss_vld,
    input  logic [TIDW-1:0]           rel_iss_tid,
    input  logic                      rel_mem_vld,
    input  logic [TIDW-1:0]           rel_mem_tid,
    input  logic                      cfg_vld,
    input  logic [NUM_THREADS-1:0]    cfg_mask,
    input  logic [1:0]                cfg_mode,
    output logic                      alloc_grant,
    output logic                      alloc_reject,
    output logic [NUM_THREADS-1:0]    thr_full,
    output logic [NUM_THREADS*CW-1:0] thr_free,
    output logic                      q_full,
    output logic [CW-1:0]             q_free,
    output logic                      cfg_busy
);

    localparam int SW = CW + 2;
    localparam logic [CW-1:0] FULL_C = CW'(NUM_ENTRIES);

    logic [NUM_THREADS-1:0]          mask_q;
    share_mode_e                     mode_q;
    logic                            recalc;
    logic [NUM_THREADS-1:0][CW-1:0]  ceil_q, ceil_nxt;
    logic [NUM_THREADS-1:0][CW-1:0]  occ_w, free_w;
    logic [NUM_THREADS-1:0][1:0]     rel_w;
    logic [NUM_THREADS-1:0]          hit_w, inc_w, deca_w, decb_w;
    logic [CW-1:0]                   q_free_q;
    logic [SW-1:0]                   rel_sum;
    logic [31:0]                     occ_sum;

    iqsa_ctrl_fsm #(.NUM_THREADS(NUM_THREADS)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_vld  (cfg_vld),
        .cfg_mask (cfg_mask),
        .cfg_mode (share_mode_e'(cfg_mode)),
        .mask_q   (mask_q),
        .mode_q   (mode_q),
        .recalc   (recalc)
    );

    iqsa_ceiling_calc #(
        .NUM_THREADS (NUM_THREADS),
        .NUM_ENTRIES (NUM_ENTRIES),
        .THRESH_PCT  (THRESH_PCT),
        .CW          (CW)
    ) u_calc (
        .mode     (mode_q),
        .mask     (mask_q),
        .ceil_cur (ceil_q),
        .ceil_nxt (ceil_nxt)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int t = 0; t < NUM_THREADS; t++) ceil_q[t] <= FULL_C;
        end else if (recalc) begin
            ceil_q <= ceil_nxt;
        end
    end

    // request and release decode
    always_comb begin
        for (int t = 0; t < NUM_THREADS; t++) begin
            hit_w[t]  = alloc_vld   && (alloc_tid   == TIDW'(t));
            deca_w[t] = rel_iss_vld && (rel_iss_tid == TIDW'(t));
            decb_w[t] = rel_mem_vld && (rel_mem_tid == TIDW'(t));
        end
    end

    assign q_full       = (q_free_q == '0);
    assign alloc_grant  = (|(hit_w & ~thr_full)) && !q_full;
    assign alloc_reject = alloc_vld && !alloc_grant;
    assign inc_w        = alloc_grant ? hit_w : '0;

    for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thr
        iqsa_thread_ctr #(.NUM_ENTRIES(NUM_ENTRIES), .CW(CW)) u_ctr (
            .clk     (clk),
            .rst_n   (rst_n),
            .inc     (inc_w[t]),
            .dec_a   (deca_w[t]),
            .dec_b   (decb_w[t]),
            .ceil    (ceil_q[t]),
            .occ     (occ_w[t]),
            .free    (free_w[t]),
            .full    (thr_full[t]),
            .rel_cnt (rel_w[t])
        );
        assign thr_free[t*CW +: CW] = free_w[t];
    end

    always_comb begin
        rel_sum = '0;
        occ_sum = '0;
        for (int t = 0; t < NUM_THREADS; t++) begin
            rel_sum = rel_sum + SW'(rel_w[t]);
            occ_sum = occ_sum + 32'(occ_w[t]);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q_free_q <= FULL_C;
        else        q_free_q <= q_free_q + CW'(rel_sum) - CW'(alloc_grant);
    end

    assign q_free   = q_free_q;
    assign cfg_busy = recalc;

    // R7: global counter agrees with the per-thread counters
    a_r7_free_matches_occ: assert property (@(posedge clk) disable iff (!rst_n)
        (32'(q_free_q) + occ_sum) == 32'(NUM_ENTRIES));
    // R9: a full queue refuses every request
    a_r9_full_refuse: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_vld && q_full) |-> (alloc_reject && !alloc_grant));
    // R8: a grant without releases consumes exactly one entry
    a_r8_grant_consumes: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_grant && !rel_iss_vld && !rel_mem_vld) |=> (q_free_q == $past(q_free_q) - CW'(1)));
    // R8: grant and reject never together
    a_r8_grant_reject_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(alloc_grant && alloc_reject));

endmodule

// File: tb/iq_share_alloc_tb.sv
module iq_share_alloc_tb;

    localparam int N  = 10;
    localparam int T  = 4;
    localparam int P  = 35;
    localparam int CW = $clog2(N + 1);
    localparam int TW = 2;

    typedef struct packed {
        logic [T*CW-1:0] free;
        logic [T-1:0]    full;
        logic [CW-1:0]   qf;
        logic            qfull;
        logic            busy;
    } snap_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic alloc_vld = 1'b0, rel_iss_vld = 1'b0, rel_mem_vld = 1'b0, cfg_vld = 1'b0;
    logic [TW-1:0] alloc_tid = '0, rel_iss_tid = '0, rel_mem_tid = '0;
    logic [T-1:0] cfg_mask = '0;
    logic [1:0] cfg_mode = '0;
    logic alloc_grant, alloc_reject, q_full, cfg_busy;
    logic [T-1:0] thr_full;
    logic [T*CW-1:0] thr_free;
    logic [CW-1:0] q_free;

    always #5 clk = ~clk;

    iq_share_alloc #(.NUM_THREADS(T), .NUM_ENTRIES(N), .THRESH_PCT(P)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .alloc_vld(alloc_vld), .alloc_tid(alloc_tid),
        .rel_iss_vld(rel_iss_vld), .rel_iss_tid(rel_iss_tid),
        .rel_mem_vld(rel_mem_vld), .rel_mem_tid(rel_mem_tid),
        .cfg_vld(cfg_vld), .cfg_mask(cfg_mask), .cfg_mode(cfg_mode),
        .alloc_grant(alloc_grant), .alloc_reject(alloc_reject),
        .thr_full(thr_full), .thr_free(thr_free),
        .q_full(q_full), .q_free(q_free), .cfg_busy(cfg_busy)
    );

    int n_checks = 0;
    int n_errors = 0;
    snap_t exp_q[$];
    string req_q[$];

    // bench reference state
    int occ_m[T];
    int ceil_m[T];
    int qfree_m;
    bit recalc_m;
    int mode_m;
    bit [T-1:0] mask_m;

    function automatic int free_of(int t);
        return (ceil_m[t] > occ_m[t]) ? ceil_m[t] - occ_m[t] : 0;
    endfunction

    task automatic check(string req, string what, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic step(bit av, int at, bit iv, int it, bit mv, int mt,
                        bit cv, bit [T-1:0] cm, bit [1:0] md, string req);
        bit g;
        int cnt;
        snap_t s;
        @(negedge clk);
        alloc_vld = av;   alloc_tid = TW'(at);
        rel_iss_vld = iv; rel_iss_tid = TW'(it);
        rel_mem_vld = mv; rel_mem_tid = TW'(mt);
        cfg_vld = cv;     cfg_mask = cm; cfg_mode = md;
        #1;
        g = av && (free_of(at) != 0) && (qfree_m != 0);
        check(req, "alloc_grant", int'(alloc_grant), int'(g));
        check(req, "alloc_reject", int'(alloc_reject), int'(av && !g));
        // ceilings rewritten in the RECALC cycle (R2, R3, R4)
        if (recalc_m) begin
            cnt = $countones(mask_m);
            for (int t = 0; t < T; t++) begin
                if (mode_m == 1) begin
                    if (mask_m[t] && cnt != 0) ceil_m[t] = N / cnt;
                end else if (mode_m == 2) begin
                    ceil_m[t] = (mask_m[t] && cnt == 1) ? N : (P * N) / 100;
                end else begin
                    ceil_m[t] = N;
                end
            end
        end
        // releases judged on held occupancy (R10), then grant (R8, R11)
        for (int t = 0; t < T; t++) begin
            int r;
            int rel;
            r = ((iv && it == t) ? 1 : 0) + ((mv && mt == t) ? 1 : 0);
            rel = (occ_m[t] < r) ? occ_m[t] : r;
            occ_m[t] -= rel;
            qfree_m += rel;
        end
        if (g) begin
            occ_m[at]++;
            qfree_m--;
        end
        if (cv) begin
            mode_m = int'(md);
            mask_m = cm;
        end
        recalc_m = cv;
        @(posedge clk);
        #1;
        for (int t = 0; t < T; t++) begin
            s.free[t*CW +: CW] = CW'(free_of(t));
            s.full[t] = (free_of(t) == 0);
        end
        s.qf = CW'(qfree_m);
        s.qfull = (qfree_m == 0);
        s.busy = recalc_m;
        exp_q.push_back(s);
        req_q.push_back(req);
    endtask

    task automatic idle(string req);
        step(0, 0, 0, 0, 0, 0, 0, '0, 2'b00, req);
    endtask
    task automatic alloc(int t, string req);
        step(1, t, 0, 0, 0, 0, 0, '0, 2'b00, req);
    endtask
    task automatic cfg(bit [T-1:0] m, bit [1:0] md, string req);
        step(0, 0, 0, 0, 0, 0, 1, m, md, req);
        idle(req);
    endtask

    // monitor: compare registered outputs against expected snapshots
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            snap_t e;
            string r;
            e = exp_q.pop_front();
            r = req_q.pop_front();
            for (int t = 0; t < T; t++) begin
                check(r, $sformatf("thr_free[%0d]", t), int'(thr_free[t*CW +: CW]),
                      int'(e.free[t*CW +: CW]));
            end
            check(r, "thr_full", int'(thr_full), int'(e.full));
            check(r, "q_free", int'(q_free), int'(e.qf));
            check(r, "q_full", int'(q_full), int'(e.qfull));
            check(r, "cfg_busy", int'(cfg_busy), int'(e.busy));
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks + 1);
        $finish;
    end

    initial begin
        for (int t = 0; t < T; t++) begin
            occ_m[t] = 0;
            ceil_m[t] = N;
        end
        qfree_m = N; recalc_m = 0; mode_m = 0; mask_m = '1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        idle("R1");
        // shared mode grants and releases
        alloc(0, "R8"); alloc(0, "R8"); alloc(0, "R8");
        step(0, 0, 0, 0, 1, 0, 0, '0, 2'b00, "R10");
        step(1, 0, 1, 0, 0, 0, 0, '0, 2'b00, "R11");
        step(0, 0, 1, 1, 0, 0, 0, '0, 2'b00, "R10");
        for (int i = 0; i < 8; i++) alloc(1, "R7");
        alloc(2, "R9");
        step(1, 1, 1, 1, 0, 0, 0, '0, 2'b00, "R9");
        for (int i = 0; i < 3; i++) step(0, 0, 1, 1, 1, 1, 0, '0, 2'b00, "R10");
        step(0, 0, 1, 1, 1, 1, 0, '0, 2'b00, "R10");
        step(0, 0, 1, 0, 1, 0, 0, '0, 2'b00, "R10");
        idle("R7");
        // even split
        cfg(4'b1111, 2'b01, "R3");
        alloc(3, "R6"); alloc(3, "R6"); alloc(3, "R6");
        cfg(4'b0111, 2'b01, "R3");
        cfg(4'b0011, 2'b01, "R3");
        for (int i = 0; i < 4; i++) alloc(0, "R8");
        cfg(4'b1111, 2'b01, "R6");
        alloc(0, "R6");
        cfg(4'b0001, 2'b01, "R3");
        cfg(4'b0000, 2'b01, "R3");
        // threshold
        cfg(4'b1111, 2'b10, "R4");
        cfg(4'b0100, 2'b10, "R4");
        for (int i = 0; i < 4; i++) alloc(2, "R4");
        cfg(4'b0110, 2'b10, "R4");
        // shared again
        cfg(4'b1010, 2'b00, "R2");
        cfg(4'b0001, 2'b11, "R2");
        // back-to-back updates keep RECALC
        step(0, 0, 0, 0, 0, 0, 1, 4'b1111, 2'b01, "R5");
        step(0, 0, 0, 0, 0, 0, 1, 4'b0011, 2'b01, "R5");
        idle("R5");
        idle("R5");
        for (int i = 0; i < 4; i++) step(0, 0, 1, 0, 1, 2, 0, '0, 2'b00, "R10");
        idle("R7");
        @(negedge clk);
        @(negedge clk);
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule